// File: doc/BRIEF.md
# Tone Generator with PWM Volume

This block makes an audio tone whose pitch comes from two programmable dividers in cascade, and whose loudness comes from a pulse-width-modulated signal taken from the inner divider. The inner counter runs on every clock and wraps at its period value. The outer counter advances once per inner wrap, and the tone square wave flips each time the outer counter wraps. A set/reset latch gives the volume signal. It is set at the inner wrap and cleared when the inner counter reaches the volume value. The sound output is the tone gated by that volume signal.

Software writes three 8-bit settings through a one-cycle write port: inner period, outer period and volume. Each setting sits in a holding register and is copied into a working buffer only when both counters wrap together. Pitch and loudness therefore change only on a tone half-period boundary, and a write never produces a torn cycle. A global enable clears the counters, the tone and the latch, and keeps every output low.

Top module: `tone_pwm_gen`

## Requirements
- R1: With inner buffer value P, the inner counter and the volume signal repeat every P+1 clocks.
- R2: With outer buffer value O, the tone output stays at each level for (P+1)*(O+1) clocks, so the tone frequency is f_clk/(2*(P+1)*(O+1)).
- R3: With volume buffer value V below P, the volume signal is high for V+1 clocks and low for P-V clocks of every period. A wider gap between P and V gives a shorter high time.
- R4: With V equal to or greater than P, the volume signal stays high continuously once set.
- R5: A written setting reaches its working buffer only at the cycle where the inner and outer counters wrap together. Until then the old timing holds.
- R6: The sound output equals the tone output ANDed with the volume signal.
- R7: While the enable is low, all three outputs are low and both counters are cleared. After the enable rises, the volume signal first goes high P+1 clocks later and the tone first goes high (P+1)*(O+1) clocks later.
- R8: After reset, all outputs are low, and the settings and buffers hold 0.
- R9: The write select encodes 0 as inner period, 1 as outer period and 2 as volume. A write with select 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Global enable; low clears counters and outputs |
| wr_en | input | 1 | Setting write strobe |
| wr_sel | input | 2 | Setting select: 0 inner, 1 outer, 2 volume, 3 none |
| wr_data | input | DATA_W (8) | Write data |
| tone_o | output | 1 | Tone square wave |
| pwm_o | output | 1 | Volume PWM signal |
| snd_o | output | 1 | Tone gated by the volume signal |

## Verification
The bench builds the block with the default 8-bit inner and outer widths. These widths allow the worked setting of inner 255 and outer 32, which gives a 256-clock volume period and an 8448-clock tone half period. Small settings such as inner 9 and outer 4 make a full tone period short enough to watch several buffer loads. They also make it possible to place a write between two loads and to count the exact cycle of the first edges after enable.

// File: rtl/tonegen_pkg.sv
package tonegen_pkg;
   localparam int SEL_W = 2;

   typedef enum logic [SEL_W-1:0] {
      SEL_INNER  = 2'd0,
      SEL_OUTER  = 2'd1,
      SEL_VOLUME = 2'd2,
      SEL_NONE   = 2'd3
   } tg_sel_e;
endpackage

// File: rtl/tg_shadow_reg.sv
module tg_shadow_reg #(
   parameter int W  = 8,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   input  logic          load,
   output logic [W-1:0]  buf_q
);
   logic [W-1:0] hold_q;

   generate
      if (W > DW) begin : g_bad_width
         $error("tg_shadow_reg: W must not exceed DW");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else if (wr) begin
         hold_q <= wdata[W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q <= '0;
      end else if (load) begin
         buf_q <= hold_q;
      end
   end

   // R5: the working buffer moves only on a load
   p_buf_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(buf_q));
endmodule

// File: rtl/tg_counter.sv
module tg_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         step,
   input  logic [W-1:0] limit,
   output logic [W-1:0] cnt,
   output logic         hit
);
   generate
      if (W < 1) begin : g_bad_width
         $error("tg_counter: W must be at least 1");
      end
   endgenerate

   assign hit = step && (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (hit) begin
         cnt <= '0;
      end else if (step) begin
         cnt <= cnt + 1'b1;
      end
   end

   // R1: a match restarts the count from zero
   p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !clr) |=> (cnt == '0));
   // R1: the count never passes its limit
   p_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= limit);
   // R7: clear forces zero
   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));
endmodule

// File: rtl/tg_pwm_latch.sv
module tg_pwm_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic set,
   input  logic drop,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= 1'b0;
      end else if (clr) begin
         q <= 1'b0;
      end else if (set) begin
         q <= 1'b1;
      end else if (drop) begin
         q <= 1'b0;
      end
   end

   // R3: set at the period match
   p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (set && !clr) |=> q);
   // R3: cleared at the volume match unless set wins
   p_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (drop && !set && !clr) |=> !q);
   // R4: otherwise the latch holds its level
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!drop && !set && !clr) |=> $stable(q));
endmodule

// File: rtl/tone_pwm_gen.sv
module tone_pwm_gen
   import tonegen_pkg::*;
#(
   parameter int INNER_W = 8,
   parameter int OUTER_W = 8,
   parameter int DATA_W  = (INNER_W > OUTER_W) ? INNER_W : OUTER_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic              tone_o,
   output logic              pwm_o,
   output logic              snd_o
);
   localparam int VOL_W = INNER_W;

   generate
      if (INNER_W < 2) begin : g_bad_inner
         $error("tone_pwm_gen: INNER_W must be at least 2");
      end
      if (DATA_W < INNER_W || DATA_W < OUTER_W) begin : g_bad_data
         $error("tone_pwm_gen: DATA_W must cover both counter widths");
      end
   endgenerate

   logic               wr_inner, wr_outer, wr_vol;
   logic [INNER_W-1:0] inner_buf, inner_cnt;
   logic [OUTER_W-1:0] outer_buf, outer_cnt;
   logic [VOL_W-1:0]   vol_buf;
   logic               inner_hit, wrap, vol_hit;
   logic               tone_q, pwm_q;

   assign wr_inner = wr_en && (wr_sel == SEL_INNER);
   assign wr_outer = wr_en && (wr_sel == SEL_OUTER);
   assign wr_vol   = wr_en && (wr_sel == SEL_VOLUME);

   tg_shadow_reg #(.W(INNER_W), .DW(DATA_W)) u_inner_reg (
      .clk(clk), .rst_n(rst_n), .wr(wr_inner), .wdata(wr_data),
      .load(wrap), .buf_q(inner_buf));

   tg_shadow_reg #(.W(OUTER_W), .DW(DATA_W)) u_outer_reg (
      .clk(clk), .rst_n(rst_n), .wr(wr_outer), .wdata(wr_data),
      .load(wrap), .buf_q(outer_buf));

   tg_shadow_reg #(.W(VOL_W), .DW(DATA_W)) u_vol_reg (
      .clk(clk), .rst_n(rst_n), .wr(wr_vol), .wdata(wr_data),
      .load(wrap), .buf_q(vol_buf));

   tg_counter #(.W(INNER_W)) u_inner_cnt (
      .clk(clk), .rst_n(rst_n), .clr(!en), .step(en),
      .limit(inner_buf), .cnt(inner_cnt), .hit(inner_hit));

   tg_counter #(.W(OUTER_W)) u_outer_cnt (
      .clk(clk), .rst_n(rst_n), .clr(!en), .step(inner_hit),
      .limit(outer_buf), .cnt(outer_cnt), .hit(wrap));

   assign vol_hit = en && (inner_cnt == vol_buf);

   tg_pwm_latch u_pwm (
      .clk(clk), .rst_n(rst_n), .clr(!en), .set(inner_hit),
      .drop(vol_hit), .q(pwm_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tone_q <= 1'b0;
      end else if (!en) begin
         tone_q <= 1'b0;
      end else if (wrap) begin
         tone_q <= !tone_q;
      end
   end

   assign tone_o = tone_q;
   assign pwm_o  = pwm_q;
   assign snd_o  = tone_q && pwm_q;

   // R7: disabled block drives nothing
   p_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!tone_o && !pwm_o && !snd_o));
   // R2: tone flips only on a double wrap
   p_tone_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !wrap) |=> $stable(tone_o));
   // R2: a double wrap always flips the tone
   p_tone_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && wrap) |=> (tone_o != $past(tone_o)));
   // R5: the outer counter only wraps at an inner match
   p_wrap_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |-> inner_hit);
endmodule

// File: tb/tb_tone_pwm_gen.sv
module tb_tone_pwm_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_sel = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic       tone_o, pwm_o, snd_o;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   tone_pwm_gen dut (
      .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .tone_o(tone_o), .pwm_o(pwm_o), .snd_o(snd_o));

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit sig(input int which);
      return (which == 0) ? pwm_o : tone_o;
   endfunction

   task automatic wr(input logic [1:0] sel, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // high and low run lengths of pwm (0) or tone (1), from a rising edge
   task automatic measure(input int which, output int hi, output int lo);
      int guard;
      hi = 0; lo = 0; guard = 0;
      @(negedge clk);
      while (sig(which) && guard < 20000) begin @(negedge clk); guard++; end
      while (!sig(which) && guard < 40000) begin @(negedge clk); guard++; end
      hi = 1;
      @(negedge clk);
      while (sig(which) && hi < 20000) begin hi++; @(negedge clk); end
      lo = 1;
      @(negedge clk);
      while (!sig(which) && lo < 20000) begin lo++; @(negedge clk); end
   endtask

   task automatic wait_tone_edge();
      bit prev;
      int guard;
      @(negedge clk);
      prev = tone_o;
      guard = 0;
      while (tone_o == prev && guard < 20000) begin @(negedge clk); guard++; end
   endtask

   task automatic t_reset();
      int bad;
      bad = 0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (tone_o || pwm_o || snd_o) bad++;
      end
      chk("R8 outputs low after reset", bad, 0);
   endtask

   task automatic t_basic();
      int hi, lo, bad, seen;
      wr(2'd0, 8'd9); wr(2'd1, 8'd4); wr(2'd2, 8'd3);
      @(negedge clk); en = 1'b1;
      repeat (200) @(negedge clk);
      measure(0, hi, lo);
      chk("R1 pwm period", hi + lo, 10);
      chk("R3 pwm high time", hi, 4);
      measure(1, hi, lo);
      chk("R2 tone high half", hi, 50);
      chk("R2 tone low half", lo, 50);
      bad = 0; seen = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (snd_o != (tone_o && pwm_o)) bad++;
         if (snd_o) seen++;
      end
      chk("R6 sound is tone AND pwm", bad, 0);
      chk("R6 sound active at times", (seen > 0) ? 1 : 0, 1);
   endtask

   task automatic t_buffered();
      int hi, lo;
      wait_tone_edge();
      wr(2'd2, 8'd7);
      measure(0, hi, lo);
      chk("R5 old volume holds before load", hi, 4);
      wait_tone_edge();
      repeat (12) @(negedge clk);
      measure(0, hi, lo);
      chk("R5 new volume after load", hi, 8);
      chk("R5 period unchanged", hi + lo, 10);
   endtask

   task automatic t_full();
      int low_cnt;
      wr(2'd2, 8'd9);
      repeat (120) @(negedge clk);
      low_cnt = 0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (!pwm_o) low_cnt++;
      end
      chk("R4 volume equal to period stays high", low_cnt, 0);
      wr(2'd2, 8'd200);
      repeat (120) @(negedge clk);
      low_cnt = 0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (!pwm_o) low_cnt++;
      end
      chk("R4 volume above period stays high", low_cnt, 0);
   endtask

   task automatic t_ignore();
      int hi, lo;
      wr(2'd2, 8'd3);
      repeat (120) @(negedge clk);
      wr(2'd3, 8'd0);
      repeat (120) @(negedge clk);
      measure(0, hi, lo);
      chk("R9 select 3 leaves volume", hi, 4);
      chk("R9 select 3 leaves period", hi + lo, 10);
      measure(1, hi, lo);
      chk("R9 select 3 leaves tone", hi, 50);
   endtask

   task automatic t_small();
      int hi, lo;
      wr(2'd0, 8'd4); wr(2'd1, 8'd1); wr(2'd2, 8'd0);
      repeat (150) @(negedge clk);
      measure(0, hi, lo);
      chk("R3 minimum volume high time", hi, 1);
      chk("R1 short pwm period", hi + lo, 5);
      measure(1, hi, lo);
      chk("R2 short tone half", hi, 10);
      chk("R2 short tone low half", lo, 10);
   endtask

   task automatic t_enable();
      int bad;
      bit p4, p5, t9, t10;
      @(negedge clk); en = 1'b0;
      @(negedge clk);
      bad = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (tone_o || pwm_o || snd_o) bad++;
      end
      chk("R7 outputs low while disabled", bad, 0);
      en = 1'b1;
      p4 = 1'b1; p5 = 1'b0; t9 = 1'b1; t10 = 1'b0;
      for (int i = 1; i <= 10; i++) begin
         @(negedge clk);
         if (i == 4) p4 = pwm_o;
         if (i == 5) p5 = pwm_o;
         if (i == 9) t9 = tone_o;
         if (i == 10) t10 = tone_o;
      end
      chk("R7 pwm low before P+1 clocks", int'(p4), 0);
      chk("R7 pwm high at P+1 clocks", int'(p5), 1);
      chk("R7 tone low before first wrap", int'(t9), 0);
      chk("R7 tone high at first wrap", int'(t10), 1);
   endtask

   task automatic t_example();
      int hi, lo;
      wr(2'd0, 8'hFF); wr(2'd1, 8'h20); wr(2'd2, 8'd127);
      repeat (100) @(negedge clk);
      measure(0, hi, lo);
      chk("R1 worked pwm period 256", hi + lo, 256);
      chk("R3 worked pwm high 128", hi, 128);
      measure(1, hi, lo);
      chk("R2 worked tone high half 8448", hi, 8448);
      chk("R2 worked tone low half 8448", lo, 8448);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_buffered();
      t_full();
      t_ignore();
      t_small();
      t_enable();
      t_example();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule